// File: doc/BRIEF.md
# Addressed Serial Octal DAC Register Bank

This block is the digital front end of an eight-channel converter. A host sends 16-bit words over a three-wire link: an active-low frame sync, a serial clock and a data line. Each word carries a 12-bit code, one device-address bit and a 3-bit channel number. When the address bit agrees with a static address pin, the code is written into the input latch of the chosen channel. Two such devices can share one link, each strapped to a different address level.

Every channel also has an output latch that holds the value the converter uses. A load input copies all eight input latches into their output latches together. A clear input zeroes the output latches and leaves the input latches alone, so a later load brings the old values back. The word held in the shift register is also sent out on a serial output, so devices can be chained.

All link and strobe inputs are sampled by a faster system clock through two-flop synchronizers. That clock must run at least four times the serial clock rate.

Top module: `octdac_front`

## Requirements
- R1: A word is 16 bits, sent most significant bit first. Word bits 15..4 hold the code (MSB first), bit 3 holds the address bit and bits 2..0 hold the channel number. A channel number of 0..7 picks the latch at `in_codes_o[ch*12 +: 12]`.
- R2: If word bit 3 differs from `addr_sel_in`, the word is dropped. No input latch changes and no write strobe is given.
- R3: Bits are taken only while `fsync_n_in` is low, one bit on each falling edge of `sclk_in`. With `fsync_n_in` high, clock edges leave the shift register and the latches unchanged.
- R4: After 16 bits, further falling clock edges are ignored until the next high-to-low edge of `fsync_n_in`, even if frame sync stays low.
- R5: While `load_n_in` is low and `clear_n_in` is high, every output latch takes the value of its input latch. While both are high, the output latches hold their values.
- R6: While `clear_n_in` is low, every output latch is zero and the input latches keep their values. A later load restores the earlier outputs.
- R7: When `clear_n_in` and `load_n_in` are low together, clear wins and the outputs stay zero.
- R8: On each rising serial clock edge, `sdata_out` presents the oldest bit in the shift register. During a word, the previous word is sent bit for bit in the order it arrived, whether or not its address matched.
- R9: Reset zeroes the shift register, the bit counter, all input latches and all output latches, and drives `sdata_out` low.
- R10: Each accepted word produces a `wr_stb_o` pulse exactly one system clock long, with `wr_chan_o` giving the channel that was written.
- R11: If `fsync_n_in` rises before 16 bits have arrived, the partial word is dropped without a write. The next word is counted from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk_in | input | 1 | Serial clock; bits are taken on its falling edge |
| fsync_n_in | input | 1 | Active-low frame sync |
| sdata_in | input | 1 | Serial data in |
| addr_sel_in | input | 1 | Static device-address level |
| load_n_in | input | 1 | Active-low level load, input latches to output latches |
| clear_n_in | input | 1 | Active-low level clear of the output latches |
| sdata_out | output | 1 | Serial data out, for chaining |
| in_codes_o | output | 96 | Eight input latches, channel n at bits n*12 +: 12 |
| out_codes_o | output | 96 | Eight output latches, same layout |
| wr_stb_o | output | 1 | One-cycle pulse for each accepted word |
| wr_chan_o | output | 3 | Channel written with the current strobe |

## Verification
The bench mixes words whose address bit matches and words whose bit does not. It checks that a mismatched word changes no latch and gives no strobe, but still comes out on the serial output during the next word; a design that gated the chained output on the address match would lose it there. It sends 20 clocks in one frame, where a design that kept shifting after 16 bits would write a shifted code. It toggles the clock with frame sync high and aborts a frame after 7 bits; a counter that did not restart would split the next word at the wrong place. It holds clear and load low together, then releases clear first, to show that clear wins and that the input latches kept their values.

// File: rtl/octdac_pkg.sv
package octdac_pkg;
  localparam int unsigned NUM_CH  = 8;
  localparam int unsigned CODE_W  = 12;
  localparam int unsigned SEL_W   = $clog2(NUM_CH);
  localparam int unsigned FRAME_W = CODE_W + 1 + SEL_W;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/octdac_sync.sv
// Multi-bit synchronizer: one independent flop chain per bit.
module octdac_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_n;

      always_comb chain_n = {chain_q[STAGES-2:0], d[b]};

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
        else        chain_q <= chain_n;
      end

      assign q[b] = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/octdac_frame_rx.sv
// Serial word receiver: edge detection, bit counting, address test, chain output.
module octdac_frame_rx #(
  parameter int unsigned CODE_W  = 12,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned FRAME_W = CODE_W + 1 + SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              fs_n_s,
  input  logic              sd_s,
  input  logic              addr_pin,
  output logic              sdo,
  output logic              commit,
  output logic [CODE_W-1:0] code,
  output logic [SEL_W-1:0]  chan
);
  localparam int unsigned CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_W - 1);
  localparam int unsigned ADDR_POS = SEL_W;

  logic               sclk_d, fs_d;
  logic               armed_q, armed_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [FRAME_W-1:0] sh_q, sh_n;
  logic               sdo_n, commit_n;
  logic [CODE_W-1:0]  code_n;
  logic [SEL_W-1:0]   chan_n;
  logic               sclk_fall, sclk_rise, fs_fall, last_bit;

  assign sclk_fall = sclk_d & ~sclk_s;
  assign sclk_rise = ~sclk_d & sclk_s;
  assign fs_fall   = fs_d & ~fs_n_s;

  always_comb begin
    armed_n  = armed_q;
    cnt_n    = cnt_q;
    sh_n     = sh_q;
    sdo_n    = sdo;
    commit_n = 1'b0;
    code_n   = code;
    chan_n   = chan;
    last_bit = 1'b0;

    if (fs_fall) begin
      armed_n = 1'b1;
      cnt_n   = '0;
    end else if (fs_n_s) begin
      armed_n = 1'b0;
    end else if (armed_q && sclk_fall) begin
      sh_n = {sh_q[FRAME_W-2:0], sd_s};
      if (cnt_q == LAST_CNT) begin
        armed_n  = 1'b0;
        cnt_n    = '0;
        last_bit = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end

    if (last_bit && (sh_n[ADDR_POS] == addr_pin)) begin
      commit_n = 1'b1;
      code_n   = sh_n[FRAME_W-1 -: CODE_W];
      chan_n   = sh_n[SEL_W-1:0];
    end

    if (sclk_rise) sdo_n = sh_q[FRAME_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      fs_d    <= 1'b1;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      sdo     <= 1'b0;
      commit  <= 1'b0;
      code    <= '0;
      chan    <= '0;
    end else begin
      sclk_d  <= sclk_s;
      fs_d    <= fs_n_s;
      armed_q <= armed_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      sdo     <= sdo_n;
      commit  <= commit_n;
      code    <= code_n;
      chan    <= chan_n;
    end
  end
endmodule

// File: rtl/octdac_latch_bank.sv
// Two-level latch bank: per-channel input latch and output latch.
module octdac_latch_bank #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CODE_W = 12,
  parameter int unsigned SEL_W  = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit,
  input  logic [CODE_W-1:0]        code,
  input  logic [SEL_W-1:0]         chan,
  input  logic                     load_n_s,
  input  logic                     clear_n_s,
  output logic [NUM_CH*CODE_W-1:0] in_flat,
  output logic [NUM_CH*CODE_W-1:0] out_flat,
  output logic                     wr_stb,
  output logic [SEL_W-1:0]         wr_chan
);
  genvar ch;
  generate
    for (ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic [CODE_W-1:0] in_q, in_n, out_q, out_n;

      always_comb begin
        in_n = in_q;
        if (commit && (chan == SEL_W'(ch))) in_n = code;
      end

      always_comb begin
        out_n = out_q;
        if (!clear_n_s)     out_n = '0;
        else if (!load_n_s) out_n = in_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          in_q  <= '0;
          out_q <= '0;
        end else begin
          in_q  <= in_n;
          out_q <= out_n;
        end
      end

      assign in_flat[ch*CODE_W +: CODE_W]  = in_q;
      assign out_flat[ch*CODE_W +: CODE_W] = out_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb  <= 1'b0;
      wr_chan <= '0;
    end else begin
      wr_stb <= commit;
      if (commit) wr_chan <= chan;
    end
  end
endmodule

// File: rtl/octdac_front.sv
module octdac_front #(
  parameter int unsigned NUM_CH = octdac_pkg::NUM_CH,
  parameter int unsigned CODE_W = octdac_pkg::CODE_W,
  parameter int unsigned SYNC_STAGES = octdac_pkg::SYNC_STAGES
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           sclk_in,
  input  logic                           fsync_n_in,
  input  logic                           sdata_in,
  input  logic                           addr_sel_in,
  input  logic                           load_n_in,
  input  logic                           clear_n_in,
  output logic                           sdata_out,
  output logic [NUM_CH*CODE_W-1:0]       in_codes_o,
  output logic [NUM_CH*CODE_W-1:0]       out_codes_o,
  output logic                           wr_stb_o,
  output logic [$clog2(NUM_CH)-1:0]      wr_chan_o
);
  localparam int unsigned SEL_W   = $clog2(NUM_CH);
  localparam int unsigned FRAME_W = CODE_W + 1 + SEL_W;

  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  // Bit order: {clear, load, fsync, data, sclk}; idle levels on reset.
  logic [4:0] raw_in, sync_out;
  logic       sclk_s, sd_s, fs_n_s, load_n_s, clear_n_s;

  assign raw_in = {clear_n_in, load_n_in, fsync_n_in, sdata_in, sclk_in};

  octdac_sync #(.WIDTH(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b11100)) u_sync (
    .clk(clk), .rst_n(rst_q_n), .d(raw_in), .q(sync_out)
  );

  assign {clear_n_s, load_n_s, fs_n_s, sd_s, sclk_s} = sync_out;

  logic              commit;
  logic [CODE_W-1:0] code;
  logic [SEL_W-1:0]  chan;

  octdac_frame_rx #(.CODE_W(CODE_W), .SEL_W(SEL_W), .FRAME_W(FRAME_W)) u_rx (
    .clk(clk), .rst_n(rst_q_n), .sclk_s(sclk_s), .fs_n_s(fs_n_s), .sd_s(sd_s),
    .addr_pin(addr_sel_in), .sdo(sdata_out), .commit(commit), .code(code), .chan(chan)
  );

  octdac_latch_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .SEL_W(SEL_W)) u_bank (
    .clk(clk), .rst_n(rst_q_n), .commit(commit), .code(code), .chan(chan),
    .load_n_s(load_n_s), .clear_n_s(clear_n_s), .in_flat(in_codes_o),
    .out_flat(out_codes_o), .wr_stb(wr_stb_o), .wr_chan(wr_chan_o)
  );
endmodule

// File: rtl/octdac_front_chk.sv
module octdac_front_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CODE_W = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     clear_n_s,
  input logic                     load_n_s,
  input logic [NUM_CH*CODE_W-1:0] in_codes,
  input logic [NUM_CH*CODE_W-1:0] out_codes,
  input logic                     wr_stb
);
  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n_s |=> (out_codes == '0));

  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_n_s && !load_n_s) |=> (out_codes == '0));

  p_load_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n_s && !load_n_s) |=> (out_codes == $past(in_codes)));

  p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n_s && load_n_s) |=> $stable(out_codes));

  p_write_needs_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> $stable(in_codes));

  p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
endmodule

bind octdac_front octdac_front_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear_n_s(clear_n_s), .load_n_s(load_n_s),
  .in_codes(in_codes_o), .out_codes(out_codes_o), .wr_stb(wr_stb_o)
);

// File: tb/octdac_front_test.sv
module octdac_front_test;
  localparam int NCH = 8;
  localparam int CW  = 12;
  localparam int NV  = 10;
  // word = {code[11:0], addr bit, channel[2:0]}; device address pin is 1
  localparam logic [15:0] VEC [0:NV-1] = '{
    16'hABC8, 16'h123F, 16'hFFFB, 16'h5555, 16'h8009,
    16'h001E, 16'h7A5A, 16'h3C34, 16'h0F0C, 16'h9998
  };

  logic clk = 1'b0;
  logic rst_n, sclk, fs_n, sdi, addr_pin, load_n, clear_n;
  logic sdo, wr_stb;
  logic [NCH*CW-1:0] in_codes, out_codes;
  logic [2:0] wr_chan;

  int n_chk = 0;
  int n_bad = 0;
  int stb_cnt = 0;
  int stb_wide = 0;
  logic prev_stb = 1'b0;
  logic [CW-1:0] model [NCH];
  logic [15:0] prev_word, seen;

  always #5 clk = ~clk;

  octdac_front uut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .fsync_n_in(fs_n), .sdata_in(sdi),
    .addr_sel_in(addr_pin), .load_n_in(load_n), .clear_n_in(clear_n),
    .sdata_out(sdo), .in_codes_o(in_codes), .out_codes_o(out_codes),
    .wr_stb_o(wr_stb), .wr_chan_o(wr_chan)
  );

  always @(posedge clk) begin
    prev_stb <= wr_stb;
    if (wr_stb) stb_cnt <= stb_cnt + 1;
    if (wr_stb && prev_stb) stb_wide <= stb_wide + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NCH*CW-1:0] flat();
    logic [NCH*CW-1:0] v;
    for (int c = 0; c < NCH; c++) v[c*CW +: CW] = model[c];
    return v;
  endfunction

  task automatic xfer(input logic [31:0] bits, input int n, output logic [31:0] got);
    got = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sdi  = bits[i];
      sclk = 1'b1;
      tick(4);
      got[i] = sdo;
      sclk = 1'b0;
      tick(4);
    end
  endtask

  task automatic send(input logic [15:0] w, input int extra, input logic [3:0] tail, output logic [15:0] got);
    logic [31:0] g;
    fs_n = 1'b0;
    tick(4);
    xfer({12'h0, w, tail} >> (4 - extra), 16 + extra, g);
    got = 16'(g >> extra);
    fs_n = 1'b1;
    tick(10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] junk;
    int s0;
    rst_n = 1'b0; sclk = 1'b0; fs_n = 1'b1; sdi = 1'b0;
    addr_pin = 1'b1; load_n = 1'b1; clear_n = 1'b1;
    for (int c = 0; c < NCH; c++) model[c] = '0;
    tick(5);
    chk(in_codes == '0 && out_codes == '0 && sdo == 1'b0, "R9 reset state",
        {in_codes[47:0], out_codes[47:0]}, '0);
    rst_n = 1'b1;
    tick(6);

    prev_word = '0;
    for (int i = 0; i < NV; i++) begin
      s0 = stb_cnt;
      send(VEC[i], 0, 4'h0, seen);
      chk(seen == prev_word, "R8 chained word", 96'(seen), 96'(prev_word));
      prev_word = VEC[i];
      if (VEC[i][3] == addr_pin) begin
        model[VEC[i][2:0]] = VEC[i][15:4];
        chk(stb_cnt == s0 + 1 && wr_chan == VEC[i][2:0], "R10 strobe/channel",
            96'(wr_chan), 96'(VEC[i][2:0]));
      end else begin
        chk(stb_cnt == s0, "R2 mismatch no strobe", 96'(stb_cnt - s0), 96'd0);
      end
      chk(in_codes == flat(), "R1 input latches", in_codes, flat());
    end
    chk(out_codes == '0, "R5 outputs hold without load", out_codes, '0);
    chk(stb_wide == 0, "R10 strobe width", 96'(stb_wide), 96'd0);

    load_n = 1'b0; tick(6); load_n = 1'b1; tick(4);
    chk(out_codes == flat(), "R5 load copies all", out_codes, flat());

    clear_n = 1'b0; tick(6);
    chk(out_codes == '0, "R6 clear zeroes outputs", out_codes, '0);
    chk(in_codes == flat(), "R6 clear keeps inputs", in_codes, flat());
    clear_n = 1'b1; tick(6);
    chk(out_codes == '0, "R6 outputs stay zero after clear", out_codes, '0);
    load_n = 1'b0; tick(6); load_n = 1'b1; tick(4);
    chk(out_codes == flat(), "R6 load restores", out_codes, flat());

    clear_n = 1'b0; load_n = 1'b0; tick(6);
    chk(out_codes == '0, "R7 clear beats load", out_codes, '0);
    clear_n = 1'b1; tick(6);
    chk(out_codes == flat(), "R7 load after clear release", out_codes, flat());
    load_n = 1'b1; tick(4);

    // R4: 20 clocks in one frame; last 4 must be ignored
    send(16'h4449, 4, 4'hF, seen);
    chk(seen == prev_word, "R8 chained word", 96'(seen), 96'(prev_word));
    prev_word = 16'h4449;
    model[1] = 12'h444;
    chk(in_codes == flat(), "R4 extra clocks ignored", in_codes, flat());

    // R3: clocks with frame sync high leave everything alone
    s0 = stb_cnt;
    xfer(32'hFFFF, 16, junk);
    tick(6);
    chk(stb_cnt == s0 && in_codes == flat(), "R3 no capture with sync high", in_codes, flat());
    send(16'h222E, 0, 4'h0, seen);
    chk(seen == prev_word, "R3 shift register untouched", 96'(seen), 96'(prev_word));
    model[6] = 12'h222;
    chk(in_codes == flat(), "R1 input latches", in_codes, flat());

    // R11: partial frame aborted
    s0 = stb_cnt;
    fs_n = 1'b0; tick(4);
    xfer(32'h7F, 7, junk);
    fs_n = 1'b1; tick(10);
    chk(stb_cnt == s0 && in_codes == flat(), "R11 partial frame dropped", in_codes, flat());
    send(16'h666B, 0, 4'h0, seen);
    model[3] = 12'h666;
    chk(in_codes == flat(), "R11 next frame counted from bit 0", in_codes, flat());

    // R9: reset mid-run
    load_n = 1'b0; tick(6); load_n = 1'b1; tick(4);
    rst_n = 1'b0; tick(3);
    chk(in_codes == '0 && out_codes == '0 && sdo == 1'b0, "R9 reset clears all",
        {in_codes[47:0], out_codes[47:0]}, '0);
    rst_n = 1'b1; tick(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule